// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block is the programming front end of an eight-line interrupt controller. A host drives a byte-wide register port with two addresses. Each written byte is sorted by its address and bit pattern into one of three kinds: a start-of-setup word, a register-select command, or a priority/end-of-interrupt command. The first kind starts a short setup sequence. The later words of that sequence load the vector base and the operating modes. Once setup is complete, writes to the upper address load the interrupt mask.

Commands written to the lower address do two things. Some update mode flags that the controller core reads every cycle. Others produce one-cycle strobes for the core: end-of-interrupt (non-specific or for a named line), set priority, and an optional rotate qualifier. Reads return the mask, the request register, the in-service register, or a poll word built from the pending line that the core reports. The priority resolution itself sits in the core, outside this block, and so does cascade arbitration. The block only tells the core what to do and reports what the core presents.

The host port uses plain one-cycle strobes, because every access completes in a single clock and never waits.

Top module: `intc_cmd_decoder`

## Requirements
- R1: After reset, every output reads 0: mask, vector base, mode flags, setup busy flag, read data, and all strobes.
- R2: A selected write to address 0 with bit 4 set starts setup. One cycle later `init_clr` pulses for one cycle and `init_busy` is 1. The same write clears the mask, register-select, rotate-on-auto-EOI, nesting mode, auto-EOI, special mask and any poll request.
- R3: The first address-1 write after a setup start loads `vec_base` with the data ANDed with 0xF8.
- R4: The setup start word decides which later words follow. Bit 1 = 0 (cascade, shown on `cascade`) adds a third word. Bit 0 = 1 adds a fourth word. `init_busy` falls after the last word that was requested.
- R5: The fourth setup word loads `nest_mode` from bit 4 and `auto_eoi` from bit 1.
- R6: When `init_busy` is 0, a selected write to address 1 loads `imr`. While `init_busy` is 1, writes to address 1 leave `imr` unchanged.
- R7: A selected write to address 0 with bit 4 = 0 and bit 3 = 1 is a register-select command. Bit 0 loads `read_isr`, bit 5 loads `spec_mask`, and bit 2 arms a poll.
- R8: A selected write to address 0 with bits 4 and 3 both 0 is a priority command, with its code in bits 7:5. Codes 0 and 4 load `rot_on_auto` from bit 7. Code 2 raises no strobe and leaves `rot_on_auto` unchanged.
- R9: Code 1 pulses `eoi_ns` with `cmd_rot` = 0. Code 5 pulses `eoi_ns` with `cmd_rot` = 1. At most one of `eoi_ns`, `eoi_sp` and `set_pri` is high in any cycle.
- R10: Code 3 pulses `eoi_sp` with `cmd_rot` = 0, and code 7 pulses it with `cmd_rot` = 1. Code 6 pulses `set_pri`. For codes 3, 6 and 7, `cmd_line` carries data bits 2:0.
- R11: When no poll is armed, a read returns the following one cycle after its strobe. Address 1 returns `imr`. Address 0 returns `isr_in` when `read_isr` = 1 and `irr_in` otherwise.
- R12: An armed poll is consumed by exactly one address-0 read. That read returns 0x80 OR `pend_line` when `pend_in` = 1, or 0x00 otherwise. When a line is pending, the read also pulses `poll_ack` with `poll_line` = that line in the same cycle as the data. The next read returns register data again.
- R13: With `sel` low, writes and reads change no state, raise no strobe and leave `rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Chip select, qualifies `wr` and `rd` |
| addr | input | 1 | Register address |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid one cycle after `rd` |
| irr_in | input | 8 | Request register from the core |
| isr_in | input | 8 | In-service register from the core |
| pend_in | input | 1 | Core has a line to deliver |
| pend_line | input | 3 | Line the core would deliver |
| init_clr | output | 1 | Pulse: core clears its request, in-service and priority base state and drops its interrupt output |
| init_busy | output | 1 | Setup sequence in progress |
| cascade | output | 1 | Cascade mode selected |
| vec_base | output | 8 | Vector base (low 3 bits zero) |
| imr | output | 8 | Interrupt mask |
| nest_mode | output | 1 | Special fully nested mode |
| auto_eoi | output | 1 | Automatic end-of-interrupt mode |
| rot_on_auto | output | 1 | Rotate on automatic end-of-interrupt |
| read_isr | output | 1 | Register reads return in-service (1) or request (0) |
| spec_mask | output | 1 | Special mask mode |
| eoi_ns | output | 1 | Pulse: non-specific end-of-interrupt |
| eoi_sp | output | 1 | Pulse: specific end-of-interrupt for `cmd_line` |
| set_pri | output | 1 | Pulse: make `cmd_line` the lowest priority |
| cmd_rot | output | 1 | Rotate qualifier for the current EOI strobe |
| cmd_line | output | 3 | Line operand of a specific command |
| poll_ack | output | 1 | Pulse: poll consumed line `poll_line`; core clears its request and in-service bits and re-evaluates |
| poll_line | output | 3 | Line taken by the poll |

## Verification
Every write-side result (mode flags, mask, vector base, busy flag and command strobes) appears on the clock edge that captures the write and lasts for the whole cycle after it. Read data and the poll acknowledge both appear on the edge that captures the read strobe. The bench drives each access on a falling edge, removes it on the next falling edge, and compares the outputs at that moment. This lands exactly in the one cycle where a strobe is high. Priority codes, register-select combinations, vector bytes and mask bytes are swept exhaustively, and every expectation is derived from the bit fields.

// File: rtl/intc_cmd_pkg.sv
package intc_cmd_pkg;
  localparam int DW      = 8;
  localparam int NLINES  = 8;
  localparam int LW      = $clog2(NLINES);
  localparam int CODE_W  = 3;
  localparam logic [DW-1:0] VBASE_MASK = {DW{1'b1}} << LW;

  // bit positions that classify a byte written to address 0
  localparam int B_SETUP = 4;
  localparam int B_RSEL  = 3;

  typedef enum logic [1:0] {
    PH_READY, PH_BASE, PH_CASC, PH_MODE
  } setup_ph_e;

  typedef enum logic [CODE_W-1:0] {
    OP_ROT_CLR    = 3'd0,
    OP_NS_EOI     = 3'd1,
    OP_NOP        = 3'd2,
    OP_SP_EOI     = 3'd3,
    OP_ROT_SET    = 3'd4,
    OP_NS_EOI_ROT = 3'd5,
    OP_SET_PRI    = 3'd6,
    OP_SP_EOI_ROT = 3'd7
  } pri_op_e;
endpackage

// File: rtl/intc_setup_seq.sv
module intc_setup_seq
  import intc_cmd_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [DW-1:0] wdata,
  output logic          init_clr,
  output logic          busy,
  output logic          cascade,
  output logic          nest_mode,
  output logic          auto_eoi,
  output logic [DW-1:0] vec_base,
  output logic [DW-1:0] imr
);
  setup_ph_e ph;
  logic      want_mode;
  logic      start;

  assign start = wr_lo && wdata[B_SETUP];
  assign busy  = (ph != PH_READY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_READY;
      want_mode <= 1'b0;
      cascade   <= 1'b0;
      nest_mode <= 1'b0;
      auto_eoi  <= 1'b0;
      vec_base  <= '0;
      imr       <= '0;
      init_clr  <= 1'b0;
    end else begin
      init_clr <= start;
      if (start) begin
        ph        <= PH_BASE;
        want_mode <= wdata[0];
        cascade   <= ~wdata[1];
        imr       <= '0;
        nest_mode <= 1'b0;
        auto_eoi  <= 1'b0;
      end else if (wr_hi) begin
        case (ph)
          PH_READY: imr <= wdata;
          PH_BASE: begin
            vec_base <= wdata & VBASE_MASK;
            if (cascade)        ph <= PH_CASC;
            else if (want_mode) ph <= PH_MODE;
            else                ph <= PH_READY;
          end
          PH_CASC: ph <= want_mode ? PH_MODE : PH_READY;
          PH_MODE: begin
            nest_mode <= wdata[4];
            auto_eoi  <= wdata[1];
            ph        <= PH_READY;
          end
          default: ph <= PH_READY;
        endcase
      end
    end
  end

  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (init_clr && busy && imr == '0 && !nest_mode && !auto_eoi));

  a_r4_mode_word_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !start && ph == PH_MODE) |=> !busy);

  a_r6_mask_held_in_setup: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> $stable(imr));
endmodule

// File: rtl/intc_cmd_dec.sv
module intc_cmd_dec
  import intc_cmd_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_lo,
  input  logic [DW-1:0] wdata,
  input  logic          poll_take,
  output logic          rot_on_auto,
  output logic          read_isr,
  output logic          spec_mask,
  output logic          poll_req,
  output logic          eoi_ns,
  output logic          eoi_sp,
  output logic          set_pri,
  output logic          cmd_rot,
  output logic [LW-1:0] cmd_line
);
  logic    is_setup, is_rsel, is_pri;
  pri_op_e op;

  assign is_setup = wr_lo && wdata[B_SETUP];
  assign is_rsel  = wr_lo && !wdata[B_SETUP] && wdata[B_RSEL];
  assign is_pri   = wr_lo && !wdata[B_SETUP] && !wdata[B_RSEL];
  assign op       = pri_op_e'(wdata[DW-1 -: CODE_W]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rot_on_auto <= 1'b0;
      read_isr    <= 1'b0;
      spec_mask   <= 1'b0;
      poll_req    <= 1'b0;
      eoi_ns      <= 1'b0;
      eoi_sp      <= 1'b0;
      set_pri     <= 1'b0;
      cmd_rot     <= 1'b0;
      cmd_line    <= '0;
    end else begin
      eoi_ns  <= 1'b0;
      eoi_sp  <= 1'b0;
      set_pri <= 1'b0;
      cmd_rot <= 1'b0;
      if (poll_take) poll_req <= 1'b0;
      if (is_setup) begin
        rot_on_auto <= 1'b0;
        read_isr    <= 1'b0;
        spec_mask   <= 1'b0;
        poll_req    <= 1'b0;
      end else if (is_rsel) begin
        read_isr  <= wdata[0];
        spec_mask <= wdata[5];
        poll_req  <= wdata[2];
      end else if (is_pri) begin
        case (op)
          OP_ROT_CLR, OP_ROT_SET: rot_on_auto <= wdata[DW-1];
          OP_NS_EOI:     eoi_ns <= 1'b1;
          OP_NS_EOI_ROT: begin eoi_ns <= 1'b1; cmd_rot <= 1'b1; end
          OP_SP_EOI: begin
            eoi_sp   <= 1'b1;
            cmd_line <= wdata[LW-1:0];
          end
          OP_SP_EOI_ROT: begin
            eoi_sp   <= 1'b1;
            cmd_rot  <= 1'b1;
            cmd_line <= wdata[LW-1:0];
          end
          OP_SET_PRI: begin
            set_pri  <= 1'b1;
            cmd_line <= wdata[LW-1:0];
          end
          default: ;
        endcase
      end
    end
  end

  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({eoi_ns, eoi_sp, set_pri}));

  a_r8_nop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pri && op == OP_NOP) |=> (!eoi_ns && !eoi_sp && !set_pri && $stable(rot_on_auto)));

  a_r10_specific_line: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pri && (op == OP_SP_EOI || op == OP_SP_EOI_ROT)) |=>
      (eoi_sp && cmd_line == $past(wdata[LW-1:0])));

  a_r12_poll_single_use: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_take && !wr_lo) |=> !poll_req);
endmodule

// File: rtl/intc_read_port.sv
module intc_read_port
  import intc_cmd_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_lo,
  input  logic          rd_hi,
  input  logic          poll_req,
  input  logic          read_isr,
  input  logic [DW-1:0] imr,
  input  logic [DW-1:0] irr_in,
  input  logic [DW-1:0] isr_in,
  input  logic          pend_in,
  input  logic [LW-1:0] pend_line,
  output logic [DW-1:0] rdata,
  output logic          poll_take,
  output logic          poll_ack,
  output logic [LW-1:0] poll_line
);
  logic [DW-1:0] poll_word;

  assign poll_take = rd_lo && poll_req;
  assign poll_word = pend_in ? ((DW'(1) << (DW-1)) | DW'(pend_line)) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata     <= '0;
      poll_ack  <= 1'b0;
      poll_line <= '0;
    end else begin
      poll_ack <= poll_take && pend_in;
      if (poll_take && pend_in) poll_line <= pend_line;
      if (rd_hi)
        rdata <= imr;
      else if (rd_lo)
        rdata <= poll_req ? poll_word : (read_isr ? isr_in : irr_in);
    end
  end

  a_r12_ack_tagged: assert property (@(posedge clk) disable iff (!rst_n)
    poll_ack |-> (rdata[DW-1] && rdata[LW-1:0] == poll_line));

  a_r11_mask_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi |=> rdata == $past(imr));
endmodule

// File: rtl/intc_cmd_decoder.sv
module intc_cmd_decoder
  import intc_cmd_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          addr,
  input  logic          wr,
  input  logic          rd,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] irr_in,
  input  logic [DW-1:0] isr_in,
  input  logic          pend_in,
  input  logic [LW-1:0] pend_line,
  output logic          init_clr,
  output logic          init_busy,
  output logic          cascade,
  output logic [DW-1:0] vec_base,
  output logic [DW-1:0] imr,
  output logic          nest_mode,
  output logic          auto_eoi,
  output logic          rot_on_auto,
  output logic          read_isr,
  output logic          spec_mask,
  output logic          eoi_ns,
  output logic          eoi_sp,
  output logic          set_pri,
  output logic          cmd_rot,
  output logic [LW-1:0] cmd_line,
  output logic          poll_ack,
  output logic [LW-1:0] poll_line
);
  logic wr_lo, wr_hi, rd_lo, rd_hi;
  logic poll_req, poll_take;

  assign wr_lo = sel && wr && !addr;
  assign wr_hi = sel && wr &&  addr;
  assign rd_lo = sel && rd && !addr;
  assign rd_hi = sel && rd &&  addr;

  intc_setup_seq u_setup (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_lo     (wr_lo),
    .wr_hi     (wr_hi),
    .wdata     (wdata),
    .init_clr  (init_clr),
    .busy      (init_busy),
    .cascade   (cascade),
    .nest_mode (nest_mode),
    .auto_eoi  (auto_eoi),
    .vec_base  (vec_base),
    .imr       (imr)
  );

  intc_cmd_dec u_cmd (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_lo       (wr_lo),
    .wdata       (wdata),
    .poll_take   (poll_take),
    .rot_on_auto (rot_on_auto),
    .read_isr    (read_isr),
    .spec_mask   (spec_mask),
    .poll_req    (poll_req),
    .eoi_ns      (eoi_ns),
    .eoi_sp      (eoi_sp),
    .set_pri     (set_pri),
    .cmd_rot     (cmd_rot),
    .cmd_line    (cmd_line)
  );

  intc_read_port u_read (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_lo     (rd_lo),
    .rd_hi     (rd_hi),
    .poll_req  (poll_req),
    .read_isr  (read_isr),
    .imr       (imr),
    .irr_in    (irr_in),
    .isr_in    (isr_in),
    .pend_in   (pend_in),
    .pend_line (pend_line),
    .rdata     (rdata),
    .poll_take (poll_take),
    .poll_ack  (poll_ack),
    .poll_line (poll_line)
  );

  a_r13_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (!init_clr && !eoi_ns && !eoi_sp && !set_pri && !poll_ack &&
              $stable(imr) && $stable(rdata)));
endmodule

// File: tb/intc_cmd_decoder_bench.sv
`timescale 1ns/1ps
module intc_cmd_decoder_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, addr = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] irr_in = '0, isr_in = '0;
  logic       pend_in = 1'b0;
  logic [2:0] pend_line = '0;
  logic       init_clr, init_busy, cascade, nest_mode, auto_eoi, rot_on_auto;
  logic       read_isr, spec_mask, eoi_ns, eoi_sp, set_pri, cmd_rot, poll_ack;
  logic [7:0] vec_base, imr;
  logic [2:0] cmd_line, poll_line;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  intc_cmd_decoder u_intc_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .sel(sel), .addr(addr), .wr(wr), .rd(rd),
    .wdata(wdata), .rdata(rdata), .irr_in(irr_in), .isr_in(isr_in),
    .pend_in(pend_in), .pend_line(pend_line), .init_clr(init_clr),
    .init_busy(init_busy), .cascade(cascade), .vec_base(vec_base), .imr(imr),
    .nest_mode(nest_mode), .auto_eoi(auto_eoi), .rot_on_auto(rot_on_auto),
    .read_isr(read_isr), .spec_mask(spec_mask), .eoi_ns(eoi_ns),
    .eoi_sp(eoi_sp), .set_pri(set_pri), .cmd_rot(cmd_rot),
    .cmd_line(cmd_line), .poll_ack(poll_ack), .poll_line(poll_line)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // access is driven on a falling edge, captured on the rising edge,
  // and removed on the next falling edge, where results are compared
  task automatic wr_b(input logic a, input logic [7:0] d, input logic s);
    @(negedge clk);
    sel = s; addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic rd_b(input logic a, input logic s);
    @(negedge clk);
    sel = s; addr = a; rd = 1'b1;
    @(negedge clk);
    sel = 1'b0; rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (all requirements): actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic exp_rot;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 imr", imr, 0);
    chk("R1 vec_base", vec_base, 0);
    chk("R1 busy", init_busy, 0);
    chk("R1 flags", {cascade, nest_mode, auto_eoi, rot_on_auto, read_isr, spec_mask}, 0);
    chk("R1 strobes", {init_clr, eoi_ns, eoi_sp, set_pri, cmd_rot, poll_ack}, 0);
    chk("R1 rdata", rdata, 0);

    // setup sequence over all start-word variants
    for (int m = 0; m < 4; m++) begin
      logic casc, want4;
      casc  = ~m[1];
      want4 = m[0];
      wr_b(1'b1, 8'hFF, 1'b1);
      wr_b(1'b0, 8'h0B, 1'b1);
      wr_b(1'b0, 8'h80, 1'b1);
      wr_b(1'b0, 8'h10 | 8'(m), 1'b1);
      chk("R2 init_clr", init_clr, 1);
      chk("R2 busy", init_busy, 1);
      chk("R2 imr cleared", imr, 0);
      chk("R2 flags cleared", {read_isr, rot_on_auto, nest_mode, auto_eoi}, 0);
      chk("R4 cascade", cascade, casc);
      wr_b(1'b1, 8'h47, 1'b1);
      chk("R2 init_clr one cycle", init_clr, 0);
      chk("R3 vec_base", vec_base, 8'h40);
      chk("R4 busy after base", init_busy, casc | want4);
      if (casc) begin
        wr_b(1'b1, 8'h00, 1'b1);
        chk("R4 busy after cascade word", init_busy, want4);
      end
      if (want4) begin
        wr_b(1'b1, 8'h12, 1'b1);
        chk("R4 busy after mode word", init_busy, 0);
        chk("R5 nest_mode", nest_mode, 1);
        chk("R5 auto_eoi", auto_eoi, 1);
      end
      wr_b(1'b1, 8'h33, 1'b1);
      chk("R6 imr after setup", imr, 8'h33);
    end

    // vector base and mode word sweep
    for (int v = 0; v < 256; v++) begin
      wr_b(1'b0, 8'h13, 1'b1);
      wr_b(1'b1, 8'(v), 1'b1);
      chk("R3 vec_base sweep", vec_base, v & 8'hF8);
      chk("R6 imr held in setup", imr, 0);
      wr_b(1'b1, 8'(v), 1'b1);
      chk("R5 nest_mode sweep", nest_mode, (v >> 4) & 1);
      chk("R5 auto_eoi sweep", auto_eoi, (v >> 1) & 1);
      chk("R4 busy done", init_busy, 0);
    end

    // mask load and read-back sweep
    for (int v = 0; v < 256; v++) begin
      wr_b(1'b1, 8'(v), 1'b1);
      chk("R6 imr sweep", imr, v);
      rd_b(1'b1, 1'b1);
      chk("R11 imr read", rdata, v);
    end

    // priority command sweep: every code with every line operand
    exp_rot = 1'b0;
    for (int c = 0; c < 8; c++) begin
      for (int l = 0; l < 8; l++) begin
        logic ens, esp, epr, ecr;
        wr_b(1'b0, 8'((c << 5) | l), 1'b1);
        ens = (c == 1) || (c == 5);
        esp = (c == 3) || (c == 7);
        epr = (c == 6);
        ecr = (c == 5) || (c == 7);
        if (c == 0 || c == 4) exp_rot = (c == 4);
        chk("R9 eoi_ns", eoi_ns, ens);
        chk("R10 eoi_sp", eoi_sp, esp);
        chk("R10 set_pri", set_pri, epr);
        chk("R9 R10 cmd_rot", cmd_rot, ecr);
        chk("R8 rot_on_auto", rot_on_auto, exp_rot);
        if (esp || epr) chk("R10 cmd_line", cmd_line, l);
        if (c == 2) chk("R8 code 2 quiet", {eoi_ns, eoi_sp, set_pri}, 0);
      end
    end

    // register-select and poll sweep
    irr_in = 8'hA5;
    isr_in = 8'h3C;
    for (int k = 0; k < 16; k++) begin
      logic b0, b2, b5, pnd;
      logic [2:0] ln;
      b0 = k[0]; b2 = k[1]; b5 = k[2]; pnd = k[3];
      ln = 3'(k) ^ 3'd5;
      pend_in = pnd;
      pend_line = ln;
      wr_b(1'b0, 8'h08 | 8'(b0) | (8'(b2) << 2) | (8'(b5) << 5), 1'b1);
      chk("R7 read_isr", read_isr, b0);
      chk("R7 spec_mask", spec_mask, b5);
      rd_b(1'b0, 1'b1);
      if (b2) begin
        chk("R12 poll word", rdata, pnd ? (8'h80 | 8'(ln)) : 8'h00);
        chk("R12 poll_ack", poll_ack, pnd);
        if (pnd) chk("R12 poll_line", poll_line, ln);
        rd_b(1'b0, 1'b1);
        chk("R12 poll consumed", rdata, b0 ? 8'h3C : 8'hA5);
        chk("R12 no second ack", poll_ack, 0);
      end else begin
        chk("R11 register read", rdata, b0 ? 8'h3C : 8'hA5);
        chk("R11 no ack", poll_ack, 0);
      end
    end

    // deselected accesses
    wr_b(1'b1, 8'hC3, 1'b1);
    rd_b(1'b1, 1'b1);
    chk("R11 imr read", rdata, 8'hC3);
    wr_b(1'b1, 8'h00, 1'b0);
    chk("R13 imr kept", imr, 8'hC3);
    wr_b(1'b0, 8'h10, 1'b0);
    chk("R13 no setup", {init_clr, init_busy}, 0);
    wr_b(1'b0, 8'h20, 1'b0);
    chk("R13 no eoi", eoi_ns, 0);
    wr_b(1'b1, 8'h11, 1'b1);
    rd_b(1'b1, 1'b0);
    chk("R13 rdata kept", rdata, 8'hC3);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule